// File: doc/BRIEF.md
# SDRAM Burst Interrupt Scheduler

This block sits between a request source and the command and data pins of an SDRAM. It takes read, write, precharge and burst-stop requests one at a time and issues them so that one burst can cut another short. It produces, cycle by cycle, the command code, the data mask (DQM), the controller's data-bus drive enable and the write data, so that the controller and the memory never drive the bus together and no stale beat reaches the array.

It keeps a shift register that records, for each coming cycle, whether the memory will return a read beat. Read beats appear CAS latency cycles after a read command. A later read, precharge or burst stop cancels only the beats due at or after its own cycle plus the CAS latency. DQM acts on read data two cycles after it is raised and on write data in the same cycle. A write that arrives while read data is still in flight is held for two cycles. During that hold DQM hides the read beats that would land on the write's first two cycles, and the write then owns the bus.

Requests use a valid/ready handshake. `req_ready` drops only during the two-cycle hold in front of a delayed write. A request offered then stays on the pins and is taken once `req_ready` returns. Write data is a stream that the block pulls with `wd_ready`, which equals the drive enable. The source cannot apply back-pressure: `wd_valid` must be high in every cycle where `wd_ready` is high.

Top module: `sdq_sched`

## Requirements
- R1: A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_op` is encoded 0 read, 1 write, 2 precharge, 3 burst stop. A taken read, precharge or burst stop puts its command on `cmd` in the same cycle. `cmd` is encoded 0 idle, 1 read, 2 write, 3 precharge, 4 burst stop.
- R2: A write taken while no read beat is expected issues `cmd`=2 in the same cycle. `dq_oe` is then high, with DQM low, for BL consecutive cycles starting in that cycle.
- R3: A write taken while any read beat is still expected gives `cmd`=0 in the taken cycle and `cmd`=2 exactly two cycles later. `req_ready` is low in the two cycles after the taken cycle.
- R4: In the taken cycle and the next cycle of a delayed write, DQM is high exactly when a read beat is expected two cycles later, and that beat is then not expected. Outside these cases and R8, DQM is low, and it is always low while `dq_oe` is high.
- R5: After a read command with nothing cutting it short, `rd_expect` is high for BL cycles starting CL cycles after the command.
- R6: A read, precharge or burst stop command in cycle t cancels the earlier read's beats due at t+CL or later. Its beats due before t+CL still arrive.
- R7: A read command during a write burst ends `dq_oe` in that same cycle. At least one cycle with `dq_oe` low lies between any driven beat and a later expected read beat.
- R8: A precharge or burst stop during a write burst ends `dq_oe` in that cycle and raises DQM in that cycle.
- R9: `dq_oe` is never high in a cycle where `rd_expect` is high. `bus_clash` flags such a cycle and therefore stays low.
- R10: While reset is held, `req_ready` is low. After reset, `cmd` is 0, `dqm`, `dq_oe` and `rd_expect` are low, and `req_ready` is high.
- R11: A write taken during a write burst restarts the burst: BL driven beats from its own command cycle.
- R12: `wd_ready` equals `dq_oe`, and `dq_out` carries `wd_data` on every driven beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | Request kind: 0 read, 1 write, 2 precharge, 3 burst stop |
| wd_valid | input | 1 | Write data present |
| wd_ready | output | 1 | Write beat consumed this cycle |
| wd_data | input | DW | Write data beat |
| cmd | output | 3 | Command: 0 idle, 1 read, 2 write, 3 precharge, 4 burst stop |
| dqm | output | 1 | Data mask to the memory |
| dq_oe | output | 1 | Controller drives the data bus |
| dq_out | output | DW | Data driven on the bus |
| rd_expect | output | 1 | Memory returns a read beat this cycle |
| bus_clash | output | 1 | Drive enable and a read beat coincide |

## Verification
The checker assumes that the write-data source keeps `wd_valid` high whenever a beat is pulled. It also assumes that requests change only between clock edges, which keeps the burst timing fixed by the command cycle. The bench holds `wd_valid` high throughout and drives requests at the falling edge. Random requests are weighted toward reads and writes, so that writes often land on read data still in flight and reads often cut into write bursts. Directed runs cover each kind of interruption at a known beat.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_PRE   = 3'd3,
    CMD_STOP  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_PRE   = 2'd2,
    OP_STOP  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD,
    ST_WGO,
    ST_WBURST
  } st_e;
endpackage

// File: rtl/sdq_rdpipe.sv
// Read-beat occupancy: bit k set means a read beat lands k cycles from now.
module sdq_rdpipe #(
  parameter int CL = 3,
  parameter int BL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic cut,
  input  logic hide,
  input  logic flush,
  output logic beat_now,
  output logic beat_any,
  output logic beat_in2
);
  localparam int P = CL + BL;

  function automatic logic [P-1:0] span(input int lo, input int hi);
    logic [P-1:0] m;
    m = '0;
    for (int i = 0; i < P; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Next-cycle view: a command now lands its first beat at position CL-1.
  localparam logic [P-1:0] LOAD_M = span(CL - 1, CL + BL - 2);
  localparam logic [P-1:0] KEEP_M = span(0, CL - 2);

  logic [P-1:0] occ, occ_n;

  always_comb begin
    occ_n = occ >> 1;
    if (flush) occ_n = '0;
    if (cut)   occ_n = occ_n & KEEP_M;
    if (hide)  occ_n[1] = 1'b0;
    if (load)  occ_n = occ_n | LOAD_M;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ_n;
  end

  assign beat_now = occ[0];
  assign beat_any = |occ;
  assign beat_in2 = occ[2];
endmodule

// File: rtl/sdq_seq.sv
module sdq_seq
  import sdq_pkg::*;
#(
  parameter int BL = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_op,
  input  logic       beat_any,
  input  logic       beat_in2,
  output logic       req_ready,
  output logic [2:0] cmd,
  output logic       dqm,
  output logic       dq_oe,
  output logic       load,
  output logic       cut,
  output logic       hide,
  output logic       flush
);
  localparam int BW = (BL > 1) ? $clog2(BL) : 1;
  localparam logic [BW-1:0] LAST = BW'(BL - 1);

  st_e st, st_n;
  logic [BW-1:0] beat, beat_n;
  cmd_e cmd_c;
  logic take, in_wr;

  always_comb begin
    req_ready = rst_n && (st == ST_IDLE || st == ST_WBURST);
    take      = req_valid && req_ready;
    in_wr     = (st == ST_WBURST);
    cmd_c     = CMD_IDLE;
    dqm       = 1'b0;
    dq_oe     = 1'b0;
    load      = 1'b0;
    cut       = 1'b0;
    hide      = 1'b0;
    flush     = 1'b0;
    st_n      = st;
    beat_n    = beat;
    case (st)
      ST_HOLD: begin
        dqm  = beat_in2;
        hide = beat_in2;
        st_n = ST_WGO;
      end
      ST_WGO: begin
        cmd_c  = CMD_WRITE;
        dq_oe  = 1'b1;
        flush  = 1'b1;
        beat_n = BW'(1);
        st_n   = (BL == 1) ? ST_IDLE : ST_WBURST;
      end
      default: begin
        if (in_wr) begin
          dq_oe = 1'b1;
          if (beat == LAST) st_n = ST_IDLE;
          else              beat_n = beat + BW'(1);
        end
        if (take) begin
          case (op_e'(req_op))
            OP_READ: begin
              cmd_c = CMD_READ;
              dq_oe = 1'b0;
              cut   = 1'b1;
              load  = 1'b1;
              st_n  = ST_IDLE;
            end
            OP_PRE, OP_STOP: begin
              cmd_c = (op_e'(req_op) == OP_PRE) ? CMD_PRE : CMD_STOP;
              dq_oe = 1'b0;
              dqm   = in_wr;
              cut   = 1'b1;
              st_n  = ST_IDLE;
            end
            default: begin
              if (beat_any) begin
                dqm   = beat_in2;
                hide  = beat_in2;
                dq_oe = 1'b0;
                st_n  = ST_HOLD;
              end else begin
                cmd_c  = CMD_WRITE;
                dq_oe  = 1'b1;
                flush  = 1'b1;
                beat_n = BW'(1);
                st_n   = (BL == 1) ? ST_IDLE : ST_WBURST;
              end
            end
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      beat <= '0;
    end else begin
      st   <= st_n;
      beat <= beat_n;
    end
  end

  assign cmd = cmd_c;
endmodule

// File: rtl/sdq_sched.sv
module sdq_sched #(
  parameter int CL = 3,
  parameter int BL = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic          wd_valid,
  output logic          wd_ready,
  input  logic [DW-1:0] wd_data,
  output logic [2:0]    cmd,
  output logic          dqm,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out,
  output logic          rd_expect,
  output logic          bus_clash
);
  logic load, cut, hide, flush;
  logic beat_now, beat_any, beat_in2;
  logic unused_wd_valid;

  sdq_rdpipe #(.CL(CL), .BL(BL)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .load(load), .cut(cut), .hide(hide), .flush(flush),
    .beat_now(beat_now), .beat_any(beat_any), .beat_in2(beat_in2)
  );

  sdq_seq #(.BL(BL)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op),
    .beat_any(beat_any), .beat_in2(beat_in2),
    .req_ready(req_ready), .cmd(cmd), .dqm(dqm), .dq_oe(dq_oe),
    .load(load), .cut(cut), .hide(hide), .flush(flush)
  );

  assign wd_ready        = dq_oe;
  assign dq_out          = wd_data;
  assign rd_expect       = beat_now;
  assign bus_clash       = dq_oe & beat_now;
  assign unused_wd_valid = wd_valid;
endmodule

// File: rtl/sdq_chk.sv
module sdq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_op,
  input logic       wd_valid,
  input logic       wd_ready,
  input logic [2:0] cmd,
  input logic       dqm,
  input logic       dq_oe,
  input logic       rd_expect,
  input logic       bus_clash
);
  AST_NO_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && rd_expect)); // R9
  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_clash); // R9
  AST_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_expect |-> !$past(dq_oe)); // R7
  AST_DRIVE_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !dqm); // R4
  AST_READ_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd0) |-> cmd == 3'd1); // R1
  AST_HOLD_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd1 && cmd == 3'd0) |=> !req_ready); // R3
  AST_WD_FED: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |-> wd_valid); // R12
endmodule

bind sdq_sched sdq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .wd_valid(wd_valid), .wd_ready(wd_ready), .cmd(cmd),
  .dqm(dqm), .dq_oe(dq_oe), .rd_expect(rd_expect), .bus_clash(bus_clash)
);

// File: tb/tb_sdq_sched.sv
`timescale 1ns/100ps
module tb_sdq_sched;
  localparam int CL = 3;
  localparam int BL = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic wd_valid = 1'b1;
  logic [DW-1:0] wd_data = '0;
  logic req_ready, wd_ready, dqm, dq_oe, rd_expect, bus_clash;
  logic [2:0] cmd;
  logic [DW-1:0] dq_out;

  sdq_sched #(.CL(CL), .BL(BL), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .wd_data(wd_data), .cmd(cmd), .dqm(dqm), .dq_oe(dq_oe),
    .dq_out(dq_out), .rd_expect(rd_expect), .bus_clash(bus_clash)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, last_oe = -10, rd_cnt = 0, oe_cnt = 0;
  bit done = 1'b0;
  bit rdm[64];
  bit wrm[64];
  bit dly[64];

  function automatic int ix(int c); return c & 63; endfunction

  task automatic chk(bit ok, string r, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", r, act, exp, cyc);
    end
  endtask

  function automatic bit pend(int c);
    for (int k = 0; k < CL + BL + 2; k++) if (rdm[ix(c + k)]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic clr_rd(int c, int from);
    for (int k = from; k < CL + BL + 4; k++) rdm[ix(c + k)] = 1'b0;
  endtask

  task automatic clr_wr(int c);
    for (int k = 0; k < BL + 2; k++) wrm[ix(c + k)] = 1'b0;
  endtask

  task automatic step(input bit v, input logic [1:0] op);
    int c;
    bit acc, rp, inwr, rdpre, wrpre;
    logic [2:0] ec;
    bit ed;
    string tg;
    @(negedge clk);
    req_valid = v;
    req_op    = op;
    wd_data   = DW'($urandom);
    #1;
    c = cyc;
    chk(req_ready == !(dly[ix(c)] || dly[ix(c + 1)]), "R3", req_ready,
        !(dly[ix(c)] || dly[ix(c + 1)]));
    acc   = req_valid && req_ready;
    rp    = pend(c);
    inwr  = wrm[ix(c)];
    rdpre = rdm[ix(c)];
    ec = 3'd0;
    tg = "R1";
    if (dly[ix(c)]) begin ec = 3'd2; tg = "R3"; end
    else if (acc) begin
      case (op)
        2'd0: ec = 3'd1;
        2'd1: begin ec = rp ? 3'd0 : 3'd2; tg = rp ? "R3" : "R2"; end
        2'd2: ec = 3'd3;
        default: ec = 3'd4;
      endcase
    end
    chk(cmd == ec, tg, cmd, ec);
    if (acc && op >= 2'd2 && inwr) begin ed = 1'b1; tg = "R8"; end
    else if ((acc && op == 2'd1 && rp) || dly[ix(c + 1)]) begin
      ed = rdm[ix(c + 2)]; tg = "R4";
    end else begin ed = 1'b0; tg = "R4"; end
    chk(dqm == ed, tg, dqm, ed);
    // apply observed command effects to the bus model
    case (cmd)
      3'd1: begin
        clr_rd(c, CL);
        for (int k = 0; k < BL; k++) rdm[ix(c + CL + k)] = 1'b1;
        clr_wr(c);
      end
      3'd2: begin
        clr_rd(c, 0);
        clr_wr(c);
        for (int k = 0; k < BL; k++) wrm[ix(c + k)] = 1'b1;
      end
      3'd3, 3'd4: begin clr_rd(c, CL); clr_wr(c); end
      default: ;
    endcase
    if (dqm) rdm[ix(c + 2)] = 1'b0;
    if (acc && op == 2'd1 && rp) dly[ix(c + 2)] = 1'b1;
    wrpre = wrm[ix(c)];
    chk(rd_expect == rdpre, "R5", rd_expect, rdpre);
    if (inwr && cmd == 3'd1)                       tg = "R7";
    else if (inwr && (cmd == 3'd3 || cmd == 3'd4)) tg = "R8";
    else if (inwr && cmd == 3'd2)                  tg = "R11";
    else                                           tg = "R2";
    chk(dq_oe == wrpre, tg, dq_oe, wrpre);
    chk(!(dq_oe && rd_expect) && !bus_clash, "R9", bus_clash, 0);
    if (rd_expect) begin
      chk(last_oe < c - 1, "R7", last_oe, c - 2);
      rd_cnt++;
    end
    chk(wd_ready == dq_oe, "R12", wd_ready, dq_oe);
    if (dq_oe) begin
      chk(dq_out == wd_data, "R12", dq_out, wd_data);
      last_oe = c;
      oe_cnt++;
    end
    rdm[ix(c)] = 1'b0;
    wrm[ix(c)] = 1'b0;
    dly[ix(c)] = 1'b0;
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10: reset behaviour
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b0, "R10", req_ready, 0);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_ready == 1'b1 && cmd == 3'd0 && !dqm && !dq_oe && !rd_expect,
        "R10", {req_ready, cmd, dqm, dq_oe, rd_expect}, 7'b1000000);

    // R5: plain read
    idle(1);
    rd_cnt = 0; step(1'b1, 2'd0); idle(9);
    chk(rd_cnt == BL, "R5", rd_cnt, BL);
    // R6: read cut by burst stop one cycle later keeps one beat
    rd_cnt = 0; step(1'b1, 2'd0); step(1'b1, 2'd3); idle(9);
    chk(rd_cnt == 1, "R6", rd_cnt, 1);
    // R6: read cut by precharge two cycles later keeps two beats
    rd_cnt = 0; step(1'b1, 2'd0); idle(1); step(1'b1, 2'd2); idle(9);
    chk(rd_cnt == 2, "R6", rd_cnt, 2);
    // R6: read followed by read two cycles later
    rd_cnt = 0; step(1'b1, 2'd0); idle(1); step(1'b1, 2'd0); idle(10);
    chk(rd_cnt == 2 + BL, "R6", rd_cnt, 2 + BL);
    // R2: plain write
    oe_cnt = 0; step(1'b1, 2'd1); idle(6);
    chk(oe_cnt == BL, "R2", oe_cnt, BL);
    // R11: write restarted after two beats
    oe_cnt = 0; step(1'b1, 2'd1); idle(1); step(1'b1, 2'd1); idle(6);
    chk(oe_cnt == 2 + BL, "R11", oe_cnt, 2 + BL);
    // R7: read interrupts write at its third beat
    oe_cnt = 0; rd_cnt = 0; step(1'b1, 2'd1); idle(1); step(1'b1, 2'd0); idle(9);
    chk(oe_cnt == 2 && rd_cnt == BL, "R7", oe_cnt, 2);
    // R8: precharge and burst stop at the second write beat
    oe_cnt = 0; step(1'b1, 2'd1); step(1'b1, 2'd2); idle(4);
    step(1'b1, 2'd1); step(1'b1, 2'd3); idle(4);
    chk(oe_cnt == 2, "R8", oe_cnt, 2);
    // R3, R4: write right behind a read, and a write held by back-pressure
    oe_cnt = 0; rd_cnt = 0; step(1'b1, 2'd0); step(1'b1, 2'd1); idle(8);
    chk(oe_cnt == BL && rd_cnt == 0, "R4", rd_cnt, 0);
    step(1'b1, 2'd0); idle(1); step(1'b1, 2'd1); step(1'b1, 2'd1); step(1'b1, 2'd1);
    idle(10);

    // constrained random traffic
    for (int i = 0; i < 5000; i++) begin
      int r;
      logic [1:0] op;
      r = $urandom_range(0, 99);
      if (r < 35) op = 2'd0;
      else if (r < 70) op = 2'd1;
      else if (r < 85) op = 2'd2;
      else op = 2'd3;
      step($urandom_range(0, 99) < 55, op);
    end
    idle(12);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5d0c_4a17));
  end
endmodule